// File: doc/BRIEF.md
# Software Write-Protection Sequence Detector

This block sits beside the write path of a byte-wide parallel non-volatile memory. It watches the chip-enable and write-enable strobes. For every write it decides whether the buffered byte may change the array. Software turns protection on by issuing a fixed series of three address/data writes. It turns protection off with a separate, longer series. Both series are parameters. A protection change takes effect only when the programming timer finishes the write period that follows the series, so reads in that period see status polling and not array data.

While protection is on, a plain write is refused, but it still opens a load window and starts the programming timer. The device therefore goes busy with nothing committed. A write placed directly after the three-write enable series is accepted, and it leaves protection on. Command writes are never stored. The protection bit lives in a register that reset leaves untouched, which models a non-volatile bit. A separate test input forces it clear.

A write is registered on the later of the two falling strobes: the first clock in which both chip enable and write enable are low. Writes that arrive while the timer reports busy are ignored. Each accepted data write restarts a load window of `LOAD_WIN` cycles. When the window runs out, the block emits a one-cycle timer-start pulse.

Top module: `sdp_guard`

## Requirements
- R1: After the protection bit has been cleared, a data write produces one `commit_en` pulse, and `prot_on` stays 0.
- R2: The enable series is the writes (13'h1555, 8'hAA), (13'h0AAA, 8'h55), (13'h1555, 8'hA0), in that order. It sets `prot_on` only when `busy` falls at the end of the following write period. `prot_on` is still 0 while `busy` is high.
- R3: While `prot_on` is 1, a data write with no enable series before it gives no `commit_en`, yet still produces one `timer_start` pulse.
- R4: While `prot_on` is 1, a data write that directly follows a complete enable series gives a `commit_en` pulse, and `prot_on` stays 1.
- R5: The disable series is (1555,AA), (0AAA,55), (1555,80), (1555,AA), (0AAA,55), (1555,20), with addresses and data in hex. It clears `prot_on` when `busy` falls at the end of the following write period.
- R6: A write that does not match the next step of a series returns that matcher to idle. The write is then handled as data. A lone final step after the matcher has gone idle does not complete the series.
- R7: Writes that form part of an enable or disable series never produce `commit_en`.
- R8: Writes that arrive while `busy` is 1 produce neither `commit_en` nor `timer_start`.
- R9: `rst_n` does not change `prot_on`. A high `force_clear` clears it.
- R10: `timer_start` pulses `LOAD_WIN` cycles after the last data write or the last step of a series. Every data write inside the window restarts it. A completed series followed by no data still starts the timer.
- R11: `commit_en` and `timer_start` are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; leaves the protection bit unchanged |
| force_clear | input | 1 | Test input that clears the protection bit |
| mem_addr | input | ADDR_W | Write address |
| mem_data | input | DATA_W | Write data |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| busy | input | 1 | The programming timer is running |
| prot_on | output | 1 | Protection is active |
| commit_en | output | 1 | Pulse: the current write may change the array |
| timer_start | output | 1 | Pulse: start the programming timer |

## Verification
The hardest situation to reach is the boundary between the two series. The disable series shares its first two steps with the enable series, and it contains them a second time, so both matchers advance, drop back to idle and restart on the same writes. The bench drives the full six-write disable series while protection is on. It then checks that the enable matcher never completes along the way and that protection clears only when `busy` falls. A broken enable series is also sent, with a wrong third write followed by a lone final step, to show that a matcher that has dropped back to idle can no longer unlock a write.

// File: rtl/sdp_pkg.sv
package sdp_pkg;

   typedef enum logic [2:0] {
      WK_NONE = 3'd0,
      WK_CMD  = 3'd1,
      WK_ENA  = 3'd2,
      WK_DIS  = 3'd3,
      WK_DATA = 3'd4
   } wr_kind_e;

   function automatic wr_kind_e classify(input logic evt, input logic ena_done,
                                         input logic dis_done, input logic any_hit);
      if (!evt)          return WK_NONE;
      else if (ena_done) return WK_ENA;
      else if (dis_done) return WK_DIS;
      else if (any_hit)  return WK_CMD;
      else               return WK_DATA;
   endfunction

endpackage

// File: rtl/sdp_strobe.sv
module sdp_strobe #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ce_n,
   input  logic we_n,
   output logic wr_evt
);
   logic stb_raw, stb_s, stb_q;

   assign stb_raw = ~ce_n & ~we_n;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign stb_s = stb_raw;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[SYNC_STAGES-2+1-1:0], stb_raw} >> 0;
         end
         assign stb_s = chain[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stb_q <= 1'b0;
      else        stb_q <= stb_s;
   end

   assign wr_evt = stb_s & ~stb_q;

endmodule

// File: rtl/sdp_seq_match.sv
module sdp_seq_match #(
   parameter int ADDR_W = 13,
   parameter int DATA_W = 8,
   parameter int LEN    = 3,
   parameter logic [LEN-1:0][ADDR_W-1:0] ADDRS = '0,
   parameter logic [LEN-1:0][DATA_W-1:0] DATAS = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   output logic              hit,
   output logic              done
);
   localparam int SW = (LEN > 1) ? $clog2(LEN) : 1;
   localparam logic [SW-1:0] LAST = SW'(LEN - 1);
   localparam logic [SW-1:0] ONE  = (LEN > 1) ? SW'(1) : '0;

   logic [SW-1:0]  step_q;
   logic [LEN-1:0] match;
   logic           nxt;

   genvar gi;
   generate
      for (gi = 0; gi < LEN; gi++) begin : g_cmp
         assign match[gi] = (addr == ADDRS[gi]) && (data == DATAS[gi]);
      end
   endgenerate

   always_comb begin
      nxt = 1'b0;
      for (int i = 0; i < LEN; i++)
         if (step_q == SW'(i)) nxt = match[i];
   end

   assign hit  = evt & (nxt | match[0]);
   assign done = evt & nxt & (step_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q <= '0;
      end else if (evt) begin
         if (nxt)           step_q <= (step_q == LAST) ? '0 : step_q + ONE;
         else if (match[0]) step_q <= ONE;
         else               step_q <= '0;
      end
   end

endmodule

// File: rtl/sdp_load_window.sv
module sdp_load_window #(
   parameter int LOAD_WIN = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic open,
   output logic fire
);
   localparam int CW = $clog2(LOAD_WIN + 1);

   logic          act_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         cnt_q <= '0;
         fire  <= 1'b0;
      end else begin
         fire <= 1'b0;
         if (open) begin
            act_q <= 1'b1;
            cnt_q <= CW'(LOAD_WIN - 1);
         end else if (act_q) begin
            if (cnt_q == '0) begin
               act_q <= 1'b0;
               fire  <= 1'b1;
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/sdp_guard.sv
module sdp_guard #(
   parameter int ADDR_W      = 13,
   parameter int DATA_W      = 8,
   parameter int EN_LEN      = 3,
   parameter int DIS_LEN     = 6,
   parameter int LOAD_WIN    = 16,
   parameter int SYNC_STAGES = 0,
   parameter logic [EN_LEN-1:0][ADDR_W-1:0]  EN_ADDR  = {13'h1555, 13'h0AAA, 13'h1555},
   parameter logic [EN_LEN-1:0][DATA_W-1:0]  EN_DATA  = {8'hA0, 8'h55, 8'hAA},
   parameter logic [DIS_LEN-1:0][ADDR_W-1:0] DIS_ADDR = {13'h1555, 13'h0AAA, 13'h1555,
                                                         13'h1555, 13'h0AAA, 13'h1555},
   parameter logic [DIS_LEN-1:0][DATA_W-1:0] DIS_DATA = {8'h20, 8'h55, 8'hAA,
                                                         8'h80, 8'h55, 8'hAA}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              force_clear,
   input  logic [ADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_data,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic              busy,
   output logic              prot_on,
   output logic              commit_en,
   output logic              timer_start
);
   import sdp_pkg::*;

   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_w
         $error("sdp_guard: widths must be positive");
      end
      if (EN_LEN < 1 || DIS_LEN < 1) begin : g_bad_len
         $error("sdp_guard: sequence lengths must be positive");
      end
      if (LOAD_WIN < 1) begin : g_bad_win
         $error("sdp_guard: LOAD_WIN must be at least 1");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("sdp_guard: SYNC_STAGES must not be negative");
      end
   endgenerate

   logic     wr_evt, evt_ok;
   logic     en_hit, en_done, dis_hit, dis_done;
   logic     armed, pend_en, pend_dis, busy_q, busy_fall;
   logic     win_open, win_fire;
   wr_kind_e kind;

   sdp_strobe #(.SYNC_STAGES(SYNC_STAGES)) u_strobe (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .wr_evt(wr_evt)
   );

   assign evt_ok = wr_evt & ~busy;

   sdp_seq_match #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN(EN_LEN), .ADDRS(EN_ADDR), .DATAS(EN_DATA)
   ) u_en_match (
      .clk(clk), .rst_n(rst_n), .evt(evt_ok), .addr(mem_addr), .data(mem_data),
      .hit(en_hit), .done(en_done)
   );

   sdp_seq_match #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN(DIS_LEN), .ADDRS(DIS_ADDR), .DATAS(DIS_DATA)
   ) u_dis_match (
      .clk(clk), .rst_n(rst_n), .evt(evt_ok), .addr(mem_addr), .data(mem_data),
      .hit(dis_hit), .done(dis_done)
   );

   assign kind = classify(evt_ok, en_done, dis_done, en_hit | dis_hit);

   assign win_open = (kind == WK_ENA) || (kind == WK_DIS) || (kind == WK_DATA);

   sdp_load_window #(.LOAD_WIN(LOAD_WIN)) u_window (
      .clk(clk), .rst_n(rst_n), .open(win_open), .fire(win_fire)
   );

   assign timer_start = win_fire;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) busy_q <= 1'b0;
      else        busy_q <= busy;
   end

   assign busy_fall = busy_q & ~busy;

   // write-period bookkeeping: unlock window and pending protection change
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed     <= 1'b0;
         pend_en   <= 1'b0;
         pend_dis  <= 1'b0;
         commit_en <= 1'b0;
      end else begin
         commit_en <= 1'b0;
         unique case (kind)
            WK_ENA: begin
               armed    <= 1'b1;
               pend_en  <= 1'b1;
               pend_dis <= 1'b0;
            end
            WK_DIS: begin
               armed    <= 1'b0;
               pend_dis <= 1'b1;
               pend_en  <= 1'b0;
            end
            WK_DATA: commit_en <= ~prot_on | armed;
            default: ;
         endcase
         if (win_fire) armed <= 1'b0;
         if (busy_fall || force_clear) begin
            pend_en  <= 1'b0;
            pend_dis <= 1'b0;
         end
      end
   end

   // protection bit: deliberately outside the reset domain (non-volatile)
   always_ff @(posedge clk) begin
      if (force_clear)               prot_on <= 1'b0;
      else if (busy_fall && pend_en)  prot_on <= 1'b1;
      else if (busy_fall && pend_dis) prot_on <= 1'b0;
   end

endmodule

// File: rtl/sdp_guard_chk.sv
module sdp_guard_chk (
   input logic clk,
   input logic rst_n,
   input logic force_clear,
   input logic busy,
   input logic armed,
   input logic prot_on,
   input logic commit_en,
   input logic timer_start
);
   // R11: outputs are single-cycle pulses
   p_commit_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      commit_en |=> !commit_en);
   p_start_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      timer_start |=> !timer_start);

   // R3: a protected write without unlock never commits
   p_commit_allowed_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(commit_en) |-> (!$past(prot_on) || $past(armed)));

   // R8: nothing is accepted during the busy period
   p_no_commit_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy) |-> !commit_en);
   p_no_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      timer_start |-> !$past(busy));

   // R2 / R5 / R9: protection changes only at the end of busy or on a forced clear
   p_prot_change_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $changed(prot_on) && !$past(force_clear) |-> ($past(busy, 2) && !$past(busy)));
   p_force_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(force_clear) |-> !prot_on);
endmodule

bind sdp_guard sdp_guard_chk u_chk (
   .clk(clk), .rst_n(rst_n), .force_clear(force_clear), .busy(busy),
   .armed(armed), .prot_on(prot_on), .commit_en(commit_en), .timer_start(timer_start)
);

// File: tb/tb_sdp_guard.sv
`timescale 1ns/1ps
module tb_sdp_guard;
   localparam int LW  = 8;
   localparam int TWC = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        force_clear = 1'b0;
   logic [12:0] mem_addr = '0;
   logic [7:0]  mem_data = '0;
   logic        ce_n = 1'b1, we_n = 1'b1;
   logic        busy;
   logic        prot_on, commit_en, timer_start;

   int total = 0, bad = 0;
   int commits = 0, starts = 0, run_c = 0, run_s = 0, max_run = 0;
   int busy_cnt = 0;

   always #10 clk = ~clk;

   sdp_guard #(.LOAD_WIN(LW)) dut (
      .clk(clk), .rst_n(rst_n), .force_clear(force_clear),
      .mem_addr(mem_addr), .mem_data(mem_data), .ce_n(ce_n), .we_n(we_n),
      .busy(busy), .prot_on(prot_on), .commit_en(commit_en), .timer_start(timer_start)
   );

   // programming timer model
   always @(posedge clk) begin
      if (timer_start)       busy_cnt <= TWC;
      else if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
   end
   assign busy = (busy_cnt != 0);

   // output monitor, sampled on the falling edge
   always @(negedge clk) begin
      if (commit_en) begin commits++; run_c++; end else run_c = 0;
      if (timer_start) begin starts++; run_s++; end else run_s = 0;
      if (run_c > max_run) max_run = run_c;
      if (run_s > max_run) max_run = run_s;
   end

   initial begin
      #(20 * 200000);
      total++; bad++;
      $display("FAIL watchdog: run did not finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [12:0] a, input logic [7:0] d);
      @(negedge clk);
      mem_addr = a; mem_data = d; ce_n = 1'b0;
      @(negedge clk);
      we_n = 1'b0;
      cyc(2);
      we_n = 1'b1; ce_n = 1'b1;
      cyc(1);
   endtask

   task automatic settle();
      cyc(LW + TWC + 10);
   endtask

   task automatic send_enable();
      wr(13'h1555, 8'hAA); wr(13'h0AAA, 8'h55); wr(13'h1555, 8'hA0);
   endtask

   task automatic t_reset();
      check(prot_on == 1'b0, "R9 cleared by force_clear", prot_on, 0);
      check(commit_en == 1'b0 && timer_start == 1'b0, "R1 idle outputs",
            {commit_en, timer_start}, 0);
   endtask

   task automatic t_plain();
      int c0 = commits, s0 = starts, n = 0;
      wr(13'h0123, 8'h3C);
      while (!timer_start && n < 100) begin cyc(1); n++; end
      check(n >= LW - 4 && n <= LW, "R10 window length", n, LW - 3);
      check(commits - c0 == 1, "R1 data write commits", commits - c0, 1);
      settle();
      check(starts - s0 == 1, "R10 one timer start", starts - s0, 1);
      check(prot_on == 1'b0, "R1 stays unprotected", prot_on, 0);
   endtask

   task automatic t_restart();
      int c0 = commits, s0 = starts;
      wr(13'h0010, 8'h01);
      wr(13'h0011, 8'h02);
      settle();
      check(commits - c0 == 2, "R10 page writes commit", commits - c0, 2);
      check(starts - s0 == 1, "R10 window restarted once", starts - s0, 1);
   endtask

   task automatic t_busy();
      int c0 = commits, s0 = starts;
      wr(13'h0020, 8'h11);
      cyc(LW + 3);
      check(busy == 1'b1, "R8 timer running", busy, 1);
      wr(13'h0021, 8'h22);
      settle();
      check(commits - c0 == 1, "R8 busy write ignored (commit)", commits - c0, 1);
      check(starts - s0 == 1, "R8 busy write ignored (start)", starts - s0, 1);
   endtask

   task automatic t_enable();
      int c0 = commits, s0 = starts;
      send_enable();
      check(commits - c0 == 0, "R7 commands not stored", commits - c0, 0);
      cyc(LW + 4);
      check(busy == 1'b1 && prot_on == 1'b0, "R2 not active during period",
            prot_on, 0);
      settle();
      check(prot_on == 1'b1, "R2 active after period", prot_on, 1);
      check(starts - s0 == 1, "R10 series alone starts timer", starts - s0, 1);
   endtask

   task automatic t_reject();
      int c0 = commits, s0 = starts;
      wr(13'h0040, 8'h5A);
      settle();
      check(commits - c0 == 0, "R3 protected write rejected", commits - c0, 0);
      check(starts - s0 == 1, "R3 rejected write starts timer", starts - s0, 1);
      check(prot_on == 1'b1, "R3 still protected", prot_on, 1);
   endtask

   task automatic t_unlock();
      int c0 = commits, s0 = starts;
      send_enable();
      wr(13'h0050, 8'hC3);
      settle();
      check(commits - c0 == 1, "R4 unlocked write commits", commits - c0, 1);
      check(starts - s0 == 1, "R4 one write period", starts - s0, 1);
      check(prot_on == 1'b1, "R4 protection kept", prot_on, 1);
      c0 = commits;
      wr(13'h0051, 8'hC4);
      settle();
      check(commits - c0 == 0, "R4 unlock used up", commits - c0, 0);
   endtask

   task automatic t_broken();
      int c0 = commits;
      wr(13'h1555, 8'hAA); wr(13'h0AAA, 8'h55);
      wr(13'h1555, 8'h77);
      wr(13'h1555, 8'hA0);
      wr(13'h0060, 8'h99);
      settle();
      check(commits - c0 == 0, "R6 broken series does not unlock", commits - c0, 0);
      check(prot_on == 1'b1, "R6 still protected", prot_on, 1);
   endtask

   task automatic t_disable();
      int c0 = commits;
      wr(13'h1555, 8'hAA); wr(13'h0AAA, 8'h55); wr(13'h1555, 8'h80);
      wr(13'h1555, 8'hAA); wr(13'h0AAA, 8'h55); wr(13'h1555, 8'h20);
      check(commits - c0 == 0, "R7 disable writes not stored", commits - c0, 0);
      cyc(LW + 4);
      check(prot_on == 1'b1, "R5 held during period", prot_on, 1);
      settle();
      check(prot_on == 1'b0, "R5 cleared after period", prot_on, 0);
      c0 = commits;
      wr(13'h0070, 8'h44);
      settle();
      check(commits - c0 == 1, "R5 writes allowed again", commits - c0, 1);
   endtask

   task automatic t_nonvol();
      send_enable();
      settle();
      check(prot_on == 1'b1, "R9 set before reset", prot_on, 1);
      rst_n = 1'b0; cyc(3); rst_n = 1'b1; cyc(2);
      check(prot_on == 1'b1, "R9 survives reset", prot_on, 1);
      force_clear = 1'b1; cyc(1); force_clear = 1'b0; cyc(1);
      check(prot_on == 1'b0, "R9 force_clear clears", prot_on, 0);
   endtask

   initial begin
      force_clear = 1'b1;
      cyc(4);
      rst_n = 1'b1;
      cyc(1);
      force_clear = 1'b0;
      cyc(2);
      t_reset();
      t_plain();
      t_restart();
      t_busy();
      t_enable();
      t_reject();
      t_unlock();
      t_broken();
      t_disable();
      t_nonvol();
      check(max_run == 1, "R11 single-cycle pulses", max_run, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule